// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block decides whether a register-indirect conditional branch is taken, and it updates the program counter when the branch is taken. The work takes two control steps. In the first step the tested register value is on the shared operand bus, the 3-bit condition selector comes from the low bits of the instruction word, and the condition-load strobe is high. The block evaluates the selected condition on the bus value and stores the result in a one-bit flag.

In the next step the branch target is presented and the target-load strobe is asserted. The program counter takes the target only if the stored flag is set. The flag is internal machine state and no software path reads or writes it. It is only exposed as a port so that it can be observed.

Top module: `cbr_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) clears both the flag and the PC to zero.
- R2: Selector 3'd0 gives a result of 0 (never) and selector 3'd1 gives 1 (always), whatever the bus value.
- R3: Selector 3'd2 gives 1 exactly when all 32 bus bits are zero. Selector 3'd3 gives 1 exactly when any bus bit is one.
- R4: Selector 3'd4 gives 1 when bus bit 31 is 0. Selector 3'd5 gives 1 when bus bit 31 is 1.
- R5: Selectors 3'd6 and 3'd7 give 0 (never taken).
- R6: The flag output takes the evaluated result one cycle after an edge at which `cond_ld_i` is high. When `cond_ld_i` is low, the flag holds its value.
- R7: At an edge where `tgt_ld_i` is high and the flag is 1, the PC becomes the full 32-bit `tgt_i`, visible after that edge.
- R8: When the flag is 0 or `tgt_ld_i` is low, the PC keeps its previous value.
- R9: The PC load uses the flag as it was stored before the edge. If both strobes are high at the same edge, the flag value from before that edge decides the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_i | input | 32 | Tested register value on the operand bus |
| csel_i | input | 3 | Condition selector from the instruction word |
| cond_ld_i | input | 1 | Strobe that captures the evaluated condition |
| tgt_ld_i | input | 1 | Strobe for a conditional PC load |
| tgt_i | input | 32 | Branch target value |
| flag_o | output | 1 | Stored condition bit |
| pc_o | output | 32 | Program counter |

## Verification
Both results are one register deep. The flag reflects the bus and selector one edge after the condition strobe. The PC reflects the target one edge after the target strobe, gated by the flag value held before that edge. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It compares the outputs at the next falling edge, so each check sees exactly one edge of effect. Back-to-back strobes, including both strobes in one cycle, check that the PC decision uses the old flag.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned CSEL_W = 3;

  typedef enum logic [CSEL_W-1:0] {
    SEL_NEVER  = 3'd0,
    SEL_ALWAYS = 3'd1,
    SEL_ZERO   = 3'd2,
    SEL_NZERO  = 3'd3,
    SEL_POS    = 3'd4,
    SEL_NEG    = 3'd5
  } csel_e;

  function automatic logic is_zero(input logic [XLEN-1:0] v);
    return ~(|v);
  endfunction
endpackage

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0]      val_i,
  input  logic [CSEL_W-1:0] sel_i,
  output logic              take_o
);
  logic zero_w;
  logic sign_w;
  logic [7:0] onehot_w;

  assign zero_w = ~(|val_i);
  assign sign_w = val_i[W-1];

  always_comb begin
    onehot_w = '0;
    onehot_w[sel_i] = 1'b1;
  end

  assign take_o = onehot_w[SEL_ALWAYS]
                | (onehot_w[SEL_ZERO]  &  zero_w)
                | (onehot_w[SEL_NZERO] & ~zero_w)
                | (onehot_w[SEL_POS]   & ~sign_w)
                | (onehot_w[SEL_NEG]   &  sign_w);

  always_comb begin
    a_never_r2: assert (!(sel_i == 3'd0 && take_o));
    a_spare_r5: assert (!(sel_i[2:1] == 2'b11 && take_o));
  end
endmodule

// File: rtl/cbr_flag.sv
module cbr_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ld_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= 1'b0;
    else if (ld_i) q_o <= d_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/cbr_pc.sv
module cbr_pc
  import cbr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [XLEN-1:0]   bus_i,
  input  logic [CSEL_W-1:0] csel_i,
  input  logic              cond_ld_i,
  input  logic              tgt_ld_i,
  input  logic [XLEN-1:0]   tgt_i,
  output logic              flag_o,
  output logic [XLEN-1:0]   pc_o
);
  logic take_w;
  logic pc_load_w;
  logic past_valid_q;

  cbr_cond_eval #(.W(XLEN)) u_eval (
    .val_i (bus_i),
    .sel_i (csel_i),
    .take_o(take_w)
  );

  cbr_flag u_flag (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .ld_i (cond_ld_i),
    .d_i  (take_w),
    .q_o  (flag_o)
  );

  assign pc_load_w = tgt_ld_i & flag_o;

  cbr_pc #(.W(XLEN)) u_pc (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .en_i (pc_load_w),
    .d_i  (tgt_i),
    .q_o  (pc_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) past_valid_q <= 1'b0;
    else       past_valid_q <= 1'b1;
  end

  p_rst_r1: assert property (@(posedge clk_i)
    rst_i |=> (pc_o == '0 && !flag_o));
  p_load_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tgt_ld_i && flag_o) |=> (pc_o == $past(tgt_i)));
  p_keep_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_valid_q && !(tgt_ld_i && flag_o)) |=> $stable(pc_o));
  p_capture_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cond_ld_i && csel_i == 3'd1) |=> flag_o);
  p_sign_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cond_ld_i && csel_i == 3'd5) |=> (flag_o == $past(bus_i[XLEN-1])));
  p_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cond_ld_i && csel_i == 3'd2) |=> (flag_o == ($past(bus_i) == '0)));
endmodule

// File: tb/cbr_unit_tb_top.sv
module cbr_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic [31:0] bus;
  logic [2:0] csel;
  logic cond_ld, tgt_ld;
  logic [31:0] tgt;
  logic flag;
  logic [31:0] pc;

  int checks = 0;
  int fails = 0;
  bit m_flag;
  logic [31:0] m_pc;

  always #2 clk = ~clk;

  cbr_unit dut_i (
    .clk_i(clk), .rst_i(rst), .bus_i(bus), .csel_i(csel),
    .cond_ld_i(cond_ld), .tgt_ld_i(tgt_ld), .tgt_i(tgt),
    .flag_o(flag), .pc_o(pc)
  );

  function automatic bit ref_cond(input logic [2:0] s, input logic [31:0] v);
    case (s)
      3'd1: return 1'b1;
      3'd2: return v == 32'd0;
      3'd3: return v != 32'd0;
      3'd4: return v[31] == 1'b0;
      3'd5: return v[31] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_flag <= 1'b0;
      m_pc <= 32'd0;
    end else begin
      if (tgt_ld && m_flag) m_pc <= tgt;
      if (cond_ld) m_flag <= ref_cond(csel, bus);
    end
  end

  task automatic cmp(input string req);
    checks++;
    if (flag !== m_flag || pc !== m_pc) begin
      fails++;
      $display("FAIL %s: flag=%0b pc=%h expected flag=%0b pc=%h",
               req, flag, pc, m_flag, m_pc);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic [31:0] v,
                      input bit cl, input bit tl, input logic [31:0] t,
                      input string req);
    csel = s; bus = v; cond_ld = cl; tgt_ld = tl; tgt = t;
    @(negedge clk);
    cmp(req);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; bus = '0; csel = '0; cond_ld = 0; tgt_ld = 0; tgt = '0;
    @(negedge clk); @(negedge clk);
    cmp("R1");
    rst = 1'b0;
    step(3'd1, 32'h0, 1, 0, 32'h0, "R2 always");
    step(3'd0, 32'h0, 0, 1, 32'hDEAD_BEE0, "R7 load");
    step(3'd0, 32'hFFFF_FFFF, 1, 0, 32'h0, "R2 never");
    step(3'd0, 32'h0, 0, 1, 32'h1234_5678, "R8 flag0");
    step(3'd2, 32'h0, 1, 0, 32'h0, "R3 zero true");
    step(3'd2, 32'h0000_0100, 1, 0, 32'h0, "R3 zero false");
    step(3'd3, 32'h8000_0000, 1, 0, 32'h0, "R3 nonzero true");
    step(3'd3, 32'h0, 1, 0, 32'h0, "R3 nonzero false");
    step(3'd4, 32'h7FFF_FFFF, 1, 0, 32'h0, "R4 sign clear");
    step(3'd4, 32'h8000_0000, 1, 0, 32'h0, "R4 sign clear false");
    step(3'd5, 32'h8000_0001, 1, 0, 32'h0, "R4 sign set");
    step(3'd0, 32'h0, 0, 0, 32'hAAAA_5555, "R8 no strobe");
    step(3'd6, 32'hFFFF_FFFF, 1, 0, 32'h0, "R5 code6");
    step(3'd1, 32'h0, 1, 0, 32'h0, "R6 set");
    step(3'd7, 32'h0, 1, 0, 32'h0, "R5 code7");
    step(3'd1, 32'h0, 0, 0, 32'h0, "R6 hold");
    step(3'd1, 32'h0, 1, 0, 32'h0, "R6 set again");
    step(3'd0, 32'h0, 1, 1, 32'h0BAD_CAFE, "R9 both strobes old flag 1");
    step(3'd1, 32'h0, 1, 1, 32'h1111_2222, "R9 both strobes old flag 0");
    step(3'd0, 32'h0, 0, 1, 32'h3333_4444, "R7 after set");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (i + 1);
      if (i % 5 == 0) v = 32'h0;
      step(3'(i % 8), v, (i % 3) != 2, (i % 2) == 1, v ^ 32'h5A5A_5A5A, "R6 mix");
    end
    rst = 1'b1;
    step(3'd1, 32'h0, 1, 1, 32'hFFFF_FFFF, "R1 reset priority");
    rst = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule